// File: doc/BRIEF.md
# Overhead byte insertion port

This block gives external logic a serial path into the overhead bytes of a SONET/SDH transmit framer. Each channel has its own port clock, a frame marker and a path-overhead indicator. The external logic watches these three outputs and replies with an insert-enable bit and a serial data bit for every bit slot. The block puts each overhead byte together from eight serial bits and reports it on a per-channel byte stream. Each reported byte carries its index, a flag that marks path overhead against transport overhead, and a replace flag. The replace flag tells the framer to use the external value in place of its own.

A frame-position counter runs each channel through `FRAME_SLOTS` byte slots per frame, eight port-clock bits per slot. In path-only mode the frame opens with the nine path-overhead bytes. In transport mode the frame opens with `TOH_BYTES` transport bytes, followed by the nine path bytes. The remaining slots are idle. A per-byte force mask can accept a byte while insert-enable is low. For the path-parity byte, an external value sets the replace flag only when a separate per-channel enable is set.

The outgoing byte stream is a timed, valid-only stream. Line timing is fixed, so it has no ready and cannot be held off. A sink must take each `byte_vld_o` pulse in the cycle it appears. The port pins are plain control signals.

Top module: `ovh_insert_port`

## Requirements
- R1: `pclk_o` runs at half the `clk` rate and is high while in reset. `frame_o` and `pohind_o` change only in a cycle where `pclk_o` falls.
- R2: `frame_o` is high for exactly one port bit, the first bit of slot 0. With `toh_mode_i`=0 that slot is the first path byte and `pohind_o` is high with it. With `toh_mode_i`=1 that slot is the first transport byte and `pohind_o` is low.
- R3: `pohind_o` is high for all eight bits of every path slot and low at all other times. The path slots are 0..8 in path-only mode and TOH_BYTES..TOH_BYTES+8 in transport mode. In transport mode, slots 0..TOH_BYTES-1 are transport slots. All other slots are idle.
- R4: Serial data is sampled at the `pclk_o` fall that ends each bit. The first bit of a slot becomes bit 7 (MSB first) of the assembled byte.
- R5: Insert-enable is read only on the first bit of a slot and is held for that byte. If it is low and the byte is not forced, the byte is reported as 0 with replace low.
- R6: A set bit in `force_poh_i` (channel c, path index i at bit c*9+i) or in `force_toh_i` (bit c*TOH_BYTES+i) accepts the byte with replace high, even when insert-enable is low.
- R7: For path index 1 (the parity byte), an accepted byte is still reported. Its replace flag is high only when `b3_ovr_i` of that channel is high.
- R8: `byte_vld_o` pulses for one `clk` cycle, in the cycle where `pclk_o` falls after the last bit of each transport or path slot. With it come `byte_idx_o` (0..8 for path bytes, 0..TOH_BYTES-1 for transport bytes) and `byte_poh_o`=1 for path bytes. Idle slots give no pulse.
- R9: While in reset, `frame_o`, `pohind_o` and `byte_vld_o` are low. No byte is reported before the first frame marker.
- R10: `toh_mode_i` is latched when a frame starts. A change within a frame takes effect at the next slot 0.
- R11: Each channel has its own pins, data and configuration, and one channel's traffic does not affect another's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| toh_mode_i | input | NCH | Per channel: 1 = transport bytes precede path bytes |
| b3_ovr_i | input | NCH | Per channel: allow replace of the path-parity byte |
| force_poh_i | input | NCH*9 | Per-byte force of path bytes |
| force_toh_i | input | NCH*TOH_BYTES | Per-byte force of transport bytes |
| pclk_o | output | NCH | Port clock per channel |
| frame_o | output | NCH | Frame marker per channel |
| pohind_o | output | NCH | Path-overhead indicator per channel |
| ins_i | input | NCH | Insert-enable per channel |
| sdata_i | input | NCH | Serial data per channel |
| byte_vld_o | output | NCH | Byte-valid strobe per channel |
| byte_data_o | output | NCH*8 | Assembled byte per channel |
| byte_idx_o | output | NCH*4 | Byte index per channel |
| byte_poh_o | output | NCH | 1 = path byte, 0 = transport byte |
| byte_rep_o | output | NCH | Replace internally generated value |

## Verification
Two things happen in the same cycle at each `pclk_o` fall. The block reports the byte just finished on the byte stream, and it updates the frame marker and indicator for the next slot. At slot boundaries, including the change from the last transport byte to the first path byte, the bench checks both against its own position model in that one cycle. The bench also changes the force mask and the mode at the same fall that opens a frame. This checks that the mask applies to the byte whose first bit follows it, and that the mode applies only to the next frame. Insert-enable is toggled randomly on every bit, so any sampling after the first bit would show up as a wrong byte.

// File: rtl/ovh_pkg.sv
package ovh_pkg;
  localparam int POH_LEN = 9;
  localparam int POH_B3_IDX = 1;

  typedef enum logic [1:0] {SLOT_IDLE, SLOT_TOH, SLOT_POH} slot_kind_e;

  typedef struct packed {
    slot_kind_e kind;
    logic [3:0] idx;
  } slot_info_t;

  function automatic slot_info_t classify(int slot, logic toh, int ntoh);
    slot_info_t r;
    r.kind = SLOT_IDLE;
    r.idx  = '0;
    if (toh) begin
      if (slot < ntoh) begin
        r.kind = SLOT_TOH;
        r.idx  = 4'(slot);
      end else if (slot < ntoh + POH_LEN) begin
        r.kind = SLOT_POH;
        r.idx  = 4'(slot - ntoh);
      end
    end else if (slot < POH_LEN) begin
      r.kind = SLOT_POH;
      r.idx  = 4'(slot);
    end
    return r;
  endfunction
endpackage

// File: rtl/ovh_pace.sv
module ovh_pace
  import ovh_pkg::*;
#(
  parameter int FRAME_SLOTS = 16,
  parameter int TOH_BYTES   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       toh_mode_i,
  output logic       pclk_o,
  output logic       frame_o,
  output logic       ind_o,
  output logic       fe_o,
  output logic       live_o,
  output logic [2:0] bit_o,
  output slot_info_t info_o
);
  localparam int SW = $clog2(FRAME_SLOTS);
  localparam logic [SW-1:0] LAST = SW'(FRAME_SLOTS - 1);

  logic          ph, live, mode_q, frame_q, ind_q;
  logic [2:0]    bit_q, nbit;
  logic [SW-1:0] slot_q, nslot;
  logic          nmode;
  slot_info_t    ninfo;

  always_comb begin
    if (!live) begin
      nbit  = 3'd0;
      nslot = '0;
      nmode = toh_mode_i;
    end else begin
      nbit  = bit_q + 3'd1;
      nslot = slot_q;
      nmode = mode_q;
      if (bit_q == 3'd7) begin
        if (slot_q == LAST) begin
          nslot = '0;
          nmode = toh_mode_i;
        end else begin
          nslot = slot_q + SW'(1);
        end
      end
    end
    ninfo = classify(int'(nslot), nmode, TOH_BYTES);
  end

  assign fe_o = !ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= 1'b0;
      live    <= 1'b0;
      mode_q  <= 1'b0;
      bit_q   <= '0;
      slot_q  <= '0;
      frame_q <= 1'b0;
      ind_q   <= 1'b0;
    end else begin
      ph <= ~ph;
      if (fe_o) begin
        live    <= 1'b1;
        bit_q   <= nbit;
        slot_q  <= nslot;
        mode_q  <= nmode;
        frame_q <= (nbit == 3'd0) && (nslot == '0);
        ind_q   <= (ninfo.kind == SLOT_POH);
      end
    end
  end

  assign pclk_o  = ~ph;
  assign frame_o = frame_q;
  assign ind_o   = ind_q;
  assign live_o  = live;
  assign bit_o   = bit_q;
  assign info_o  = classify(int'(slot_q), mode_q, TOH_BYTES);
endmodule

// File: rtl/ovh_deser.sv
module ovh_deser
  import ovh_pkg::*;
#(
  parameter int TOH_BYTES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fe_i,
  input  logic                 live_i,
  input  logic [2:0]           bit_i,
  input  slot_info_t           info_i,
  input  logic                 ins_i,
  input  logic                 sd_i,
  input  logic [POH_LEN-1:0]   force_poh_i,
  input  logic [TOH_BYTES-1:0] force_toh_i,
  input  logic                 b3_en_i,
  output logic                 vld_o,
  output logic [7:0]           data_o,
  output logic [3:0]           idx_o,
  output logic                 poh_o,
  output logic                 rep_o
);
  logic [15:0] fp, ft;
  logic        frc, acc_q, acc_now, is_poh, last_bit;
  logic [7:0]  sh_q, asm_byte;

  assign fp = 16'(force_poh_i);
  assign ft = 16'(force_toh_i);

  always_comb begin
    case (info_i.kind)
      SLOT_POH: frc = fp[info_i.idx];
      SLOT_TOH: frc = ft[info_i.idx];
      default:  frc = 1'b0;
    endcase
  end

  assign acc_now  = (bit_i == 3'd0) ? (ins_i | frc) : acc_q;
  assign asm_byte = {sh_q[6:0], sd_i};
  assign is_poh   = (info_i.kind == SLOT_POH);
  assign last_bit = (bit_i == 3'd7) && (info_i.kind != SLOT_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      acc_q  <= 1'b0;
      vld_o  <= 1'b0;
      data_o <= '0;
      idx_o  <= '0;
      poh_o  <= 1'b0;
      rep_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (fe_i && live_i) begin
        sh_q <= asm_byte;
        if (bit_i == 3'd0) acc_q <= ins_i | frc;
        if (last_bit) begin
          vld_o  <= 1'b1;
          data_o <= acc_now ? asm_byte : 8'h00;
          idx_o  <= info_i.idx;
          poh_o  <= is_poh;
          rep_o  <= acc_now &&
                    !(is_poh && (info_i.idx == 4'(POH_B3_IDX)) && !b3_en_i);
        end
      end
    end
  end
endmodule

// File: rtl/ovh_insert_port.sv
module ovh_insert_port
  import ovh_pkg::*;
#(
  parameter int NCH         = 3,
  parameter int FRAME_SLOTS = 16,
  parameter int TOH_BYTES   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           toh_mode_i,
  input  logic [NCH-1:0]           b3_ovr_i,
  input  logic [NCH*POH_LEN-1:0]   force_poh_i,
  input  logic [NCH*TOH_BYTES-1:0] force_toh_i,
  output logic [NCH-1:0]           pclk_o,
  output logic [NCH-1:0]           frame_o,
  output logic [NCH-1:0]           pohind_o,
  input  logic [NCH-1:0]           ins_i,
  input  logic [NCH-1:0]           sdata_i,
  output logic [NCH-1:0]           byte_vld_o,
  output logic [NCH*8-1:0]         byte_data_o,
  output logic [NCH*4-1:0]         byte_idx_o,
  output logic [NCH-1:0]           byte_poh_o,
  output logic [NCH-1:0]           byte_rep_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic       fe, live;
    logic [2:0] bitn;
    slot_info_t info;

    ovh_pace #(.FRAME_SLOTS(FRAME_SLOTS), .TOH_BYTES(TOH_BYTES)) pace_i (
      .clk(clk), .rst_n(rst_n), .toh_mode_i(toh_mode_i[c]),
      .pclk_o(pclk_o[c]), .frame_o(frame_o[c]), .ind_o(pohind_o[c]),
      .fe_o(fe), .live_o(live), .bit_o(bitn), .info_o(info)
    );

    ovh_deser #(.TOH_BYTES(TOH_BYTES)) deser_i (
      .clk(clk), .rst_n(rst_n), .fe_i(fe), .live_i(live), .bit_i(bitn),
      .info_i(info), .ins_i(ins_i[c]), .sd_i(sdata_i[c]),
      .force_poh_i(force_poh_i[c*POH_LEN +: POH_LEN]),
      .force_toh_i(force_toh_i[c*TOH_BYTES +: TOH_BYTES]),
      .b3_en_i(b3_ovr_i[c]),
      .vld_o(byte_vld_o[c]), .data_o(byte_data_o[c*8 +: 8]),
      .idx_o(byte_idx_o[c*4 +: 4]), .poh_o(byte_poh_o[c]),
      .rep_o(byte_rep_o[c])
    );
  end
endmodule

// File: rtl/ovh_insert_port_chk.sv
module ovh_insert_port_chk #(
  parameter int NCH       = 3,
  parameter int TOH_BYTES = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   b3_ovr_i,
  input logic [NCH-1:0]   pclk_o,
  input logic [NCH-1:0]   frame_o,
  input logic [NCH-1:0]   pohind_o,
  input logic [NCH-1:0]   byte_vld_o,
  input logic [NCH*4-1:0] byte_idx_o,
  input logic [NCH-1:0]   byte_poh_o,
  input logic [NCH-1:0]   byte_rep_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_marks_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(frame_o[c]) || !$stable(pohind_o[c])) |-> $fell(pclk_o[c]));

    assert_frame_one_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pclk_o[c]) && $past(frame_o[c])) |-> !frame_o[c]);

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o[c] |=> !byte_vld_o[c]);

    assert_valid_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o[c] |-> $fell(pclk_o[c]));

    assert_b3_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_o[c] && byte_poh_o[c] && (byte_idx_o[c*4 +: 4] == 4'd1) &&
       !$past(b3_ovr_i[c])) |-> !byte_rep_o[c]);
  end
endmodule

bind ovh_insert_port ovh_insert_port_chk #(.NCH(NCH), .TOH_BYTES(TOH_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .b3_ovr_i(b3_ovr_i), .pclk_o(pclk_o),
  .frame_o(frame_o), .pohind_o(pohind_o), .byte_vld_o(byte_vld_o),
  .byte_idx_o(byte_idx_o), .byte_poh_o(byte_poh_o), .byte_rep_o(byte_rep_o)
);

// File: tb/ovh_insert_port_tb.sv
module ovh_insert_port_tb_top;
  localparam int NCH = 3;
  localparam int FS  = 16;
  localparam int NT  = 3;
  localparam int NFRAMES = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]    toh_mode_i = '0, b3_ovr_i = '0, ins_i = '0, sdata_i = '0;
  logic [NCH*9-1:0]  force_poh_i = '0;
  logic [NCH*NT-1:0] force_toh_i = '0;
  logic [NCH-1:0]    pclk_o, frame_o, pohind_o, byte_vld_o, byte_poh_o, byte_rep_o;
  logic [NCH*8-1:0]  byte_data_o;
  logic [NCH*4-1:0]  byte_idx_o;

  always #5 clk = ~clk;

  ovh_insert_port #(.NCH(NCH), .FRAME_SLOTS(FS), .TOH_BYTES(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .toh_mode_i(toh_mode_i), .b3_ovr_i(b3_ovr_i),
    .force_poh_i(force_poh_i), .force_toh_i(force_toh_i), .pclk_o(pclk_o),
    .frame_o(frame_o), .pohind_o(pohind_o), .ins_i(ins_i), .sdata_i(sdata_i),
    .byte_vld_o(byte_vld_o), .byte_data_o(byte_data_o), .byte_idx_o(byte_idx_o),
    .byte_poh_o(byte_poh_o), .byte_rep_o(byte_rep_o)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, int ch, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s ch%0d: actual %0d expected %0d", req, ch, act, exp);
    end
  endtask

  // 0 idle, 1 transport, 2 path
  function automatic int kind_of(int slot, bit toh);
    if (toh) return (slot < NT) ? 1 : (slot < NT + 9) ? 2 : 0;
    return (slot < 9) ? 2 : 0;
  endfunction

  function automatic int idx_of(int slot, bit toh);
    if (toh) return (slot < NT) ? slot : slot - NT;
    return slot;
  endfunction

  int b[NCH], s[NCH], fr[NCH], insmode[NCH];
  bit m[NCH], acc[NCH], pend[NCH];
  logic [7:0] shm[NCH], e_data[NCH];
  int e_idx[NCH];
  bit e_poh[NCH], e_rep[NCH];

  initial begin
    void'($urandom(32'd4242));
    repeat (4) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        chk(pclk_o[c] == 1'b1, "R1 pclk in reset", c, pclk_o[c], 1);
        chk(frame_o[c] == 1'b0 && pohind_o[c] == 1'b0, "R9 marks in reset", c,
            {frame_o[c], pohind_o[c]}, 0);
        chk(byte_vld_o[c] == 1'b0, "R9 vld in reset", c, byte_vld_o[c], 0);
      end
    end
    toh_mode_i = 3'b010;
    rst_n = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      b[c] = -1; s[c] = 0; fr[c] = -1; pend[c] = 0; shm[c] = 0;
    end
    for (int n = 0; n < NFRAMES * FS * 8; n++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        int k, ix;
        bit fz, iv, dv;
        chk(pclk_o[c] == 1'b0, "R1 pclk low after fall", c, pclk_o[c], 0);
        chk(byte_vld_o[c] == pend[c], "R8 vld", c, byte_vld_o[c], pend[c]);
        if (pend[c] && byte_vld_o[c]) begin
          chk(byte_data_o[c*8 +: 8] == e_data[c], "R4 R5 R11 data", c,
              byte_data_o[c*8 +: 8], e_data[c]);
          chk(byte_idx_o[c*4 +: 4] == 4'(e_idx[c]), "R8 idx", c,
              byte_idx_o[c*4 +: 4], e_idx[c]);
          chk(byte_poh_o[c] == e_poh[c], "R8 poh flag", c, byte_poh_o[c], e_poh[c]);
          chk(byte_rep_o[c] == e_rep[c], "R5 R6 R7 rep", c, byte_rep_o[c], e_rep[c]);
        end
        // advance model position
        if (b[c] < 0) begin b[c] = 0; s[c] = 0; end
        else begin
          b[c]++;
          if (b[c] == 8) begin b[c] = 0; s[c] = (s[c] == FS - 1) ? 0 : s[c] + 1; end
        end
        if (b[c] == 0 && s[c] == 0) begin
          m[c] = toh_mode_i[c];  // R10: latched at frame start
          fr[c]++;
          insmode[c] = (fr[c] % 4 == 1) ? 1 : (fr[c] % 4 == 2) ? 2 : 0;
          b3_ovr_i[c] = (fr[c] % 4 == 3) ? 1'b1 : (fr[c] % 4 == 2) ? 1'b0 : 1'($urandom);
          for (int i = 0; i < 9; i++)
            force_poh_i[c*9 + i] = (insmode[c] == 1) ? 1'b1 : 1'($urandom % 4 == 0);
          for (int i = 0; i < NT; i++)
            force_toh_i[c*NT + i] = (insmode[c] == 1) ? 1'b1 : 1'($urandom % 4 == 0);
          toh_mode_i[c] = (fr[c] % 3 == 0) ? ~toh_mode_i[c] : 1'($urandom);
        end
        k = kind_of(s[c], m[c]);
        ix = idx_of(s[c], m[c]);
        chk(frame_o[c] == (b[c] == 0 && s[c] == 0), "R2 frame", c, frame_o[c],
            (b[c] == 0 && s[c] == 0));
        chk(pohind_o[c] == (k == 2), "R3 R10 indicator", c, pohind_o[c], (k == 2));
        iv = (insmode[c] == 1) ? 1'b0 : (insmode[c] == 2) ? 1'b1 : 1'($urandom);
        dv = 1'($urandom);
        ins_i[c] = iv;
        sdata_i[c] = dv;
        fz = (k == 2) ? force_poh_i[c*9 + ix] : (k == 1) ? force_toh_i[c*NT + ix] : 1'b0;
        if (b[c] == 0) acc[c] = iv | fz;
        shm[c] = {shm[c][6:0], dv};
        pend[c] = (b[c] == 7) && (k != 0);
        e_data[c] = acc[c] ? shm[c] : 8'h00;
        e_idx[c] = ix;
        e_poh[c] = (k == 2);
        e_rep[c] = acc[c] && !((k == 2) && ix == 1 && !b3_ovr_i[c]);
      end
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        chk(pclk_o[c] == 1'b1, "R1 pclk high", c, pclk_o[c], 1);
        chk(byte_vld_o[c] == 1'b0, "R8 vld single cycle", c, byte_vld_o[c], 0);
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule